// File: doc/BRIEF.md
# Four-Level Priority Beat Arbiter

This block decides which of several DMA channels may drive the shared bus master port for the next beat. Every channel presents a pending-request bit, an enable bit and a 2-bit priority level. The arbiter registers a one-hot grant together with a grant-valid flag. The granted channel moves exactly one beat. It then pulses `beat_done`, and the arbiter competes the port again.

Level 3 is the most urgent and level 0 the least. The highest level that has an eligible request always wins. Among channels that share that level, service rotates: the search starts just after the channel that was last granted at that level. Each level keeps its own rotation pointer. A channel counts as eligible only while both its request and its enable are high. A request dropped before it is granted therefore never receives a grant. The channel count is a parameter, with a default of 12.

Top module: `prio_beat_arbiter`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `grant` is all zeros and `grant_vld` is 0.
- R2: If no channel has both `req` and `chan_en` high while the arbiter is idle, then `grant_vld` stays 0 and `grant` stays zero at the next edge.
- R3: A grant is registered at the clock edge where the arbiter is idle and at least one channel is eligible. It is one-hot (bit i means channel i) and goes only to a channel whose `req` and `chan_en` were both high before that edge.
- R4: A channel whose `chan_en` bit is 0 is never granted, whatever its request or level.
- R5: The channel's level is `prio[2*i+1:2*i]`, where 3 is the highest and 0 the lowest. The grant always goes to a channel at the highest level among the eligible channels.
- R6: Within the winning level, the grant goes to the first eligible channel found by counting upward, with wrap-around, from the channel last granted at that level. After reset, every level starts its search at channel 0.
- R7: While `grant_vld` is high and `beat_done` is low, `grant` and `grant_vld` hold their values, even if requests, enables or levels change.
- R8: `beat_done` high while `grant_vld` is high clears `grant` and `grant_vld` at the next edge. Arbitration resumes at the edge after that.
- R9: A request raised and then withdrawn while another channel holds the port is not granted once the port is released.
- R10: Each level has its own rotation pointer. Grants at one level do not move the rotation of another level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NCH | Pending request per channel |
| chan_en | input | NCH | Channel enable; a 0 masks the channel |
| prio | input | 2*NCH | 2-bit level per channel, channel i in bits 2i+1:2i |
| beat_done | input | 1 | Pulse from the grant owner when its beat ends |
| grant | output | NCH | One-hot registered grant |
| grant_vld | output | 1 | High while a grant is held |

## Verification
Several request patterns drive the main function. A single lone requester shows the basic grant, the hold and the release gap. A mix of three levels shows that only the top level wins. Masking the top channel shows that the next level takes over. Three channels on one level, served repeatedly, show rotation and its wrap-around. Interleaving a second level between rounds of the first shows that each level keeps its own pointer. A request that appears and disappears during someone else's beat shows that withdrawn requests are dropped.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int LVL_W = 2;
  localparam int N_LVL = 1 << LVL_W;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/arb_level_sel.sv
module arb_level_sel
  import arb_pkg::*;
#(
  parameter int NCH = 12
) (
  input  logic [NCH-1:0]       active,
  input  logic [LVL_W*NCH-1:0] prio,
  output lvl_t                 top_lvl,
  output logic [NCH-1:0]       lvl_mask
);
  logic [N_LVL-1:0] has_lvl;

  // one OR tree per level
  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    logic [NCH-1:0] at_lvl;
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign at_lvl[c] = active[c] && (prio[LVL_W*c +: LVL_W] == lvl_t'(l));
    end
    assign has_lvl[l] = |at_lvl;
  end

  always_comb begin
    top_lvl = '0;
    for (int l = 0; l < N_LVL; l++) begin
      if (has_lvl[l]) top_lvl = lvl_t'(l);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_mask
    assign lvl_mask[c] = active[c] && (prio[LVL_W*c +: LVL_W] == top_lvl);
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NCH = 12,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] cand,
  input  logic [IW-1:0]  last,
  output logic [IW-1:0]  pick,
  output logic           hit
);
  always_comb begin
    pick = '0;
    hit  = 1'b0;
    for (int k = 1; k <= NCH; k++) begin
      int j;
      j = (int'(last) + k) % NCH;
      if (!hit && cand[j]) begin
        hit  = 1'b1;
        pick = j[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/prio_beat_arbiter.sv
module prio_beat_arbiter
  import arb_pkg::*;
#(
  parameter int NCH = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       req,
  input  logic [NCH-1:0]       chan_en,
  input  logic [LVL_W*NCH-1:0] prio,
  input  logic                 beat_done,
  output logic [NCH-1:0]       grant,
  output logic                 grant_vld
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] active, lvl_mask, grant_q, next_oh;
  lvl_t           top_lvl;
  logic [IW-1:0]  last_q [N_LVL];
  logic [IW-1:0]  pick;
  logic           hit, vld_q;

  assign active = req & chan_en;

  arb_level_sel #(.NCH(NCH)) u_lvl (
    .active  (active),
    .prio    (prio),
    .top_lvl (top_lvl),
    .lvl_mask(lvl_mask)
  );

  arb_rr_pick #(.NCH(NCH)) u_rr (
    .cand(lvl_mask),
    .last(last_q[top_lvl]),
    .pick(pick),
    .hit (hit)
  );

  always_comb begin
    next_oh       = '0;
    next_oh[pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      vld_q   <= 1'b0;
      for (int l = 0; l < N_LVL; l++) last_q[l] <= IW'(NCH - 1);
    end else if (vld_q) begin
      if (beat_done) begin
        grant_q <= '0;
        vld_q   <= 1'b0;
      end
    end else if (hit) begin
      grant_q         <= next_oh;
      vld_q           <= 1'b1;
      last_q[top_lvl] <= pick;
    end
  end

  assign grant     = grant_q;
  assign grant_vld = vld_q;

  a_r3_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_q) && (vld_q == (grant_q != '0)));

  a_r3_from_eligible: assert property (@(posedge clk) disable iff (rst)
    !vld_q |=> ((grant_q & ~$past(active)) == '0));

  a_r2_idle_stays_low: assert property (@(posedge clk) disable iff (rst)
    (!vld_q && (active == '0)) |=> !vld_q);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !beat_done) |=> (vld_q && $stable(grant_q)));

  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    (vld_q && beat_done) |=> !vld_q);
endmodule

// File: tb/prio_beat_arbiter_bench.sv
`timescale 1ns/1ps
module prio_beat_arbiter_bench;
  localparam int NCH = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NCH-1:0]   req = '0;
  logic [NCH-1:0]   chan_en = '1;
  logic [2*NCH-1:0] prio = '0;
  logic             beat_done = 1'b0;
  logic [NCH-1:0]   grant;
  logic             grant_vld;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_beat_arbiter #(.NCH(NCH)) u_prio_beat_arbiter (
    .clk(clk), .rst(rst), .req(req), .chan_en(chan_en), .prio(prio),
    .beat_done(beat_done), .grant(grant), .grant_vld(grant_vld)
  );

  task automatic chk(input int exp_ch, input string tag);
    logic [NCH-1:0] eg;
    logic ev;
    eg = '0;
    ev = 1'b0;
    if (exp_ch >= 0) begin
      eg[exp_ch] = 1'b1;
      ev = 1'b1;
    end
    checks++;
    if (grant !== eg || grant_vld !== ev) begin
      errors++;
      $display("FAIL %s grant=%b vld=%b expected grant=%b vld=%b", tag, grant, grant_vld, eg, ev);
    end
  endtask

  task automatic expect_grant(input int exp_ch, input string tag);
    @(posedge clk); #2;
    chk(exp_ch, tag);
  endtask

  task automatic finish_beat();
    @(negedge clk) beat_done = 1'b1;
    @(posedge clk); #2;
    beat_done = 1'b0;
    chk(-1, "R8 release");
  endtask

  task automatic set_lvl(input int ch, input int lvl);
    prio[2*ch +: 2] = 2'(lvl);
  endtask

  task automatic t_reset();
    @(posedge clk); #2;
    chk(-1, "R1 in reset");
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #2;
    chk(-1, "R1 after reset");
  endtask

  task automatic t_idle();
    @(negedge clk) req = '0;
    expect_grant(-1, "R2 idle");
  endtask

  task automatic t_single();
    @(negedge clk) begin req = '0; req[5] = 1'b1; set_lvl(5, 0); end
    expect_grant(5, "R3 single");
    @(negedge clk) begin req = '0; chan_en = '0; prio = '1; end
    repeat (3) expect_grant(5, "R7 hold");
    @(negedge clk) chan_en = '1;
    finish_beat();
    expect_grant(-1, "R2 after release");
  endtask

  task automatic t_priority();
    @(negedge clk) begin
      prio = '0; req = '0;
      req[1] = 1'b1; set_lvl(1, 1);
      req[7] = 1'b1; set_lvl(7, 3);
      req[3] = 1'b1; set_lvl(3, 2);
    end
    expect_grant(7, "R5 top level");
    finish_beat();
    @(negedge clk) chan_en[7] = 1'b0;
    expect_grant(3, "R4 masked top");
    finish_beat();
    @(negedge clk) begin chan_en = '1; req = '0; end
  endtask

  task automatic t_rotate();
    @(negedge clk) begin
      prio = '0; req = '0;
      req[2] = 1'b1; set_lvl(2, 1);
      req[4] = 1'b1; set_lvl(4, 1);
      req[9] = 1'b1; set_lvl(9, 1);
    end
    expect_grant(2, "R6 first");
    finish_beat();
    expect_grant(4, "R6 second");
    finish_beat();
    expect_grant(9, "R6 third");
    finish_beat();
    expect_grant(2, "R6 wrap");
    finish_beat();
  endtask

  task automatic t_per_level();
    // level 2 pointer sits at channel 3, level 1 pointer at channel 2
    @(negedge clk) begin
      req[0] = 1'b1; set_lvl(0, 2);
      req[6] = 1'b1; set_lvl(6, 2);
    end
    expect_grant(6, "R10 level2 after 3");
    finish_beat();
    expect_grant(0, "R10 level2 wrap");
    finish_beat();
    @(negedge clk) begin req[0] = 1'b0; req[6] = 1'b0; end
    expect_grant(4, "R10 level1 resumes");
    finish_beat();
    @(negedge clk) req = '0;
  endtask

  task automatic t_withdraw();
    @(negedge clk) begin prio = '0; req = '0; req[5] = 1'b1; end
    expect_grant(5, "R3 owner");
    @(negedge clk) begin req = '0; req[8] = 1'b1; set_lvl(8, 3); end
    expect_grant(5, "R7 hold vs higher");
    @(negedge clk) req[8] = 1'b0;
    finish_beat();
    expect_grant(-1, "R9 withdrawn");
  endtask

  initial begin
    t_reset();
    t_idle();
    t_single();
    t_priority();
    t_rotate();
    t_per_level();
    t_withdraw();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule